// File: doc/BRIEF.md
# Indirect Configuration Access Decoder

This block turns a pair of host-visible ports into configuration accesses on a set of targets. The first port holds a 32-bit pointer register. Software loads it with a target bus, a device/function slot, a dword index and an enable flag. The second port is a 4-byte data window. A byte, halfword or word access to that window becomes a single target access. The offset of that access is made from the dword index in the pointer and the byte lane of the window access.

A bitmap input tells the decoder which bus/slot pairs hold a target. The access is dropped in any of these cases: the pointer is disabled, its two low bits are not zero, the width code is reserved, or the slot is empty. A dropped write has no effect and a dropped read returns zero. Reads that do reach a target return data in the cycle of the access. That data is cut to the access width and zero-extended to 32 bits.

Every data-window cycle is sorted into one decision state: `DEC_IDLE` (no access), `DEC_OFF` (enable clear), `DEC_MISALIGN` (pointer bits 1:0 nonzero), `DEC_BADSIZE` (reserved width), `DEC_EMPTY` (slot not populated) or `DEC_FWD` (sent to the target). The checks are applied in that priority order. Each cycle is sorted afresh, so any state can follow any state. The pointer register has two states: it is either loaded by a word write on the pointer port or it holds.

Top module: `cfgp_decoder`

## Requirements
- R1: After reset the pointer register is 0, so a word read of the pointer port returns 0 and data-window accesses are dropped.
- R2: A pointer-port write with width code 2 (word) stores all 32 bits of write data, and a pointer-port word read returns the stored value in the same cycle.
- R3: A pointer-port access with width code 0, 1 or 3 is ignored: a write leaves the pointer unchanged and a read returns 0.
- R4: While pointer bit 31 is 0, a data-window write produces no target access and a data-window read returns 0.
- R5: While pointer bits 1:0 are nonzero, data-window accesses are dropped (no target access, read returns 0).
- R6: A forwarded access presents the bus from pointer bits 23:16, the device/function from pointer bits 15:8, the write flag and the write data to the target.
- R7: The target offset is {pointer bits 7:2, window lane bits 1:0}.
- R8: Width codes 0 = byte, 1 = halfword and 2 = word are passed to the target unchanged; code 3 drops the access.
- R9: A bus number of NUM_BUS or above, or a clear bit at index bus*256+devfn of the slot map, drops the access.
- R10: A forwarded read returns the target data masked to the access width (8, 16 or 32 low bits) in the same cycle; every other data-window access returns 0.
- R11: When a pointer write and a data-window access fall in the same cycle, the data access is decoded with the pointer value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_valid | input | 1 | Pointer-port access this cycle |
| ptr_write | input | 1 | Pointer-port access is a write |
| ptr_size | input | 2 | Pointer-port width code |
| ptr_wdata | input | 32 | Pointer-port write data |
| ptr_rdata | output | 32 | Pointer-port read data |
| win_valid | input | 1 | Data-window access this cycle |
| win_write | input | 1 | Data-window access is a write |
| win_lane | input | 2 | Byte lane within the window |
| win_size | input | 2 | Data-window width code |
| win_wdata | input | 32 | Data-window write data |
| win_rdata | output | 32 | Data-window read data, zero-extended |
| slot_map | input | NUM_BUS*256 | Populated-slot bitmap, bit bus*256+devfn |
| tgt_valid | output | 1 | Target access strobe |
| tgt_write | output | 1 | Target access is a write |
| tgt_bus | output | 8 | Target bus number |
| tgt_devfn | output | 8 | Target device/function |
| tgt_offset | output | 8 | Byte offset into configuration space |
| tgt_size | output | 2 | Width code passed to the target |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32 | Target read data, right-justified |

## Verification
A pointer-port word write and a data-window access can occur in the same cycle. The bench provokes this in both directions. In one direction it reloads the pointer from a populated slot to an empty one in the same cycle as a window read. In the other it reloads from an empty slot to a populated one. The scoreboard's model applies the pointer update only after it has formed that cycle's expectation. A read that reaches the old target, followed by a miss on the next cycle (or the reverse), confirms that the decode used the old pointer value.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int PTR_W      = 32;
    localparam int FIELD_W    = 8;
    localparam int SLOTS      = 1 << FIELD_W;
    localparam int EN_BIT     = 31;
    localparam int BUS_LSB    = 16;
    localparam int DEVFN_LSB  = 8;
    localparam int IDX_LSB    = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        DEC_IDLE     = 3'd0,
        DEC_OFF      = 3'd1,
        DEC_MISALIGN = 3'd2,
        DEC_BADSIZE  = 3'd3,
        DEC_EMPTY    = 3'd4,
        DEC_FWD      = 3'd5
    } dec_e;

    function automatic logic [PTR_W-1:0] width_mask(acc_size_e s);
        logic [PTR_W-1:0] m;
        unique case (s)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_HALF: m = 32'h0000_FFFF;
            SZ_WORD: m = 32'hFFFF_FFFF;
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgp_ptr_reg.sv
module cfgp_ptr_reg
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_valid,
    input  logic             ptr_write,
    input  acc_size_e        ptr_size,
    input  logic [PTR_W-1:0] ptr_wdata,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_rdata
);

    typedef enum logic {PR_HOLD, PR_LOAD} pr_op_e;

    pr_op_e op;
    logic   word_acc;

    assign word_acc = ptr_valid && (ptr_size == SZ_WORD);

    always_comb begin
        op = (word_acc && ptr_write) ? PR_LOAD : PR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                PR_LOAD: ptr_q <= ptr_wdata;
                PR_HOLD: ptr_q <= ptr_q;
                default: ptr_q <= ptr_q;
            endcase
        end
    end

    always_comb begin
        ptr_rdata = '0;
        if (word_acc && !ptr_write) begin
            ptr_rdata = ptr_q;
        end
    end

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_valid && ptr_write && ptr_size == SZ_WORD) |=> (ptr_q == $past(ptr_wdata)));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_valid && ptr_write && ptr_size != SZ_WORD) |=> $stable(ptr_q));

    // R3
    ptr_narrow_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_valid && !ptr_write && ptr_size != SZ_WORD) |-> (ptr_rdata == '0));

endmodule

// File: rtl/cfgp_slot_lookup.sv
module cfgp_slot_lookup
    import cfgp_pkg::*;
#(
    parameter int NUM_BUS = 2,
    localparam int MAP_W  = NUM_BUS * SLOTS,
    localparam int BUS_BW = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic [MAP_W-1:0]   slot_map,
    input  logic [FIELD_W-1:0] bus,
    input  logic [FIELD_W-1:0] devfn,
    output logic               present
);

    generate
        if (NUM_BUS >= SLOTS) begin : g_all_buses
            assign present = slot_map[{bus, devfn}];
        end else begin : g_some_buses
            logic in_range;
            logic [BUS_BW-1:0] bus_lo;
            assign in_range = (bus < FIELD_W'(NUM_BUS));
            assign bus_lo   = bus[BUS_BW-1:0];
            assign present  = in_range && slot_map[{bus_lo, devfn}];
        end
    endgenerate

endmodule

// File: rtl/cfgp_classifier.sv
module cfgp_classifier
    import cfgp_pkg::*;
(
    input  logic       win_valid,
    input  logic       ptr_en,
    input  logic [1:0] ptr_low,
    input  acc_size_e  win_size,
    input  logic       present,
    output dec_e       dec
);

    always_comb begin
        if (!win_valid) begin
            dec = DEC_IDLE;
        end else if (!ptr_en) begin
            dec = DEC_OFF;
        end else if (ptr_low != 2'b00) begin
            dec = DEC_MISALIGN;
        end else if (win_size == SZ_RSVD) begin
            dec = DEC_BADSIZE;
        end else if (!present) begin
            dec = DEC_EMPTY;
        end else begin
            dec = DEC_FWD;
        end
    end

endmodule

// File: rtl/cfgp_decoder.sv
module cfgp_decoder
    import cfgp_pkg::*;
#(
    parameter int NUM_BUS = 2,
    localparam int MAP_W  = NUM_BUS * 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_valid,
    input  logic              ptr_write,
    input  logic [1:0]        ptr_size,
    input  logic [31:0]       ptr_wdata,
    output logic [31:0]       ptr_rdata,
    input  logic              win_valid,
    input  logic              win_write,
    input  logic [1:0]        win_lane,
    input  logic [1:0]        win_size,
    input  logic [31:0]       win_wdata,
    output logic [31:0]       win_rdata,
    input  logic [MAP_W-1:0]  slot_map,
    output logic              tgt_valid,
    output logic              tgt_write,
    output logic [7:0]        tgt_bus,
    output logic [7:0]        tgt_devfn,
    output logic [7:0]        tgt_offset,
    output logic [1:0]        tgt_size,
    output logic [31:0]       tgt_wdata,
    input  logic [31:0]       tgt_rdata
);

    logic [PTR_W-1:0]   ptr_q;
    logic [FIELD_W-1:0] f_bus;
    logic [FIELD_W-1:0] f_devfn;
    logic [FIELD_W-1:0] f_offset;
    logic               present;
    acc_size_e          w_size;
    dec_e               dec;

    assign w_size   = acc_size_e'(win_size);
    assign f_bus    = ptr_q[BUS_LSB +: FIELD_W];
    assign f_devfn  = ptr_q[DEVFN_LSB +: FIELD_W];
    assign f_offset = {ptr_q[DEVFN_LSB-1:IDX_LSB], win_lane};

    cfgp_ptr_reg u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_valid (ptr_valid),
        .ptr_write (ptr_write),
        .ptr_size  (acc_size_e'(ptr_size)),
        .ptr_wdata (ptr_wdata),
        .ptr_q     (ptr_q),
        .ptr_rdata (ptr_rdata)
    );

    cfgp_slot_lookup #(.NUM_BUS(NUM_BUS)) u_lookup (
        .slot_map (slot_map),
        .bus      (f_bus),
        .devfn    (f_devfn),
        .present  (present)
    );

    cfgp_classifier u_class (
        .win_valid (win_valid),
        .ptr_en    (ptr_q[EN_BIT]),
        .ptr_low   (ptr_q[IDX_LSB-1:0]),
        .win_size  (w_size),
        .present   (present),
        .dec       (dec)
    );

    always_comb begin
        tgt_valid  = 1'b0;
        tgt_write  = 1'b0;
        tgt_bus    = '0;
        tgt_devfn  = '0;
        tgt_offset = '0;
        tgt_size   = '0;
        tgt_wdata  = '0;
        win_rdata  = '0;
        unique case (dec)
            DEC_FWD: begin
                tgt_valid  = 1'b1;
                tgt_write  = win_write;
                tgt_bus    = f_bus;
                tgt_devfn  = f_devfn;
                tgt_offset = f_offset;
                tgt_size   = win_size;
                tgt_wdata  = win_wdata;
                if (!win_write) begin
                    win_rdata = tgt_rdata & width_mask(w_size);
                end
            end
            DEC_IDLE, DEC_OFF, DEC_MISALIGN, DEC_BADSIZE, DEC_EMPTY: begin
                win_rdata = '0;
            end
            default: begin
                win_rdata = '0;
            end
        endcase
    end

    // R4
    tgt_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> ptr_q[EN_BIT]);

    // R5
    tgt_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (ptr_q[IDX_LSB-1:0] == 2'b00));

    // R8
    tgt_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (tgt_size != 2'd3));

    // R9
    tgt_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> present);

    // R10
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rdata != '0) |-> (tgt_valid && !tgt_write && win_valid));

    // R1
    reset_ptr_chk: assert property (@(posedge clk)
        !rst_n |=> (ptr_q == '0));

endmodule

// File: tb/cfgp_decoder_bench.sv
`timescale 1ns/1ps
module cfgp_decoder_bench;

    localparam int NB    = 2;
    localparam int MAPW  = NB * 256;

    typedef struct {
        logic [31:0] a_rd;
        logic [31:0] d_rd;
        logic        tv;
        logic        tw;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [7:0]  off;
        logic [1:0]  sz;
        logic [31:0] wd;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_valid = 1'b0, ptr_write = 1'b0;
    logic [1:0] ptr_size = '0;
    logic [31:0] ptr_wdata = '0;
    logic [31:0] ptr_rdata;
    logic win_valid = 1'b0, win_write = 1'b0;
    logic [1:0] win_lane = '0, win_size = '0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic [MAPW-1:0] slot_map = '0;
    logic tgt_valid, tgt_write;
    logic [7:0] tgt_bus, tgt_devfn, tgt_offset;
    logic [1:0] tgt_size;
    logic [31:0] tgt_wdata;
    logic [31:0] tgt_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit reported = 1'b0;
    logic [31:0] m_ptr = '0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    cfgp_decoder #(.NUM_BUS(NB)) u_cfgp_decoder (
        .clk(clk), .rst_n(rst_n),
        .ptr_valid(ptr_valid), .ptr_write(ptr_write), .ptr_size(ptr_size),
        .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .win_valid(win_valid), .win_write(win_write), .win_lane(win_lane),
        .win_size(win_size), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .slot_map(slot_map),
        .tgt_valid(tgt_valid), .tgt_write(tgt_write), .tgt_bus(tgt_bus),
        .tgt_devfn(tgt_devfn), .tgt_offset(tgt_offset), .tgt_size(tgt_size),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    function automatic logic populated(logic [7:0] b, logic [7:0] d);
        if (b >= 8'(NB)) return 1'b0;
        return slot_map[int'(b) * 256 + int'(d)];
    endfunction

    function automatic logic [31:0] msk(logic [1:0] s);
        if (s == 2'd0) return 32'hFF;
        if (s == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic cyc(input logic av, input logic aw, input logic [1:0] asz,
                       input logic [31:0] awd, input logic dv, input logic dw,
                       input logic [1:0] dln, input logic [1:0] dsz,
                       input logic [31:0] dwd, input logic [31:0] trd,
                       input string tag);
        exp_t e;
        logic fwd;
        @(negedge clk);
        ptr_valid = av; ptr_write = aw; ptr_size = asz; ptr_wdata = awd;
        win_valid = dv; win_write = dw; win_lane = dln; win_size = dsz;
        win_wdata = dwd; tgt_rdata = trd;
        fwd = dv && m_ptr[31] && (m_ptr[1:0] == 2'b00) && (dsz != 2'd3)
              && populated(m_ptr[23:16], m_ptr[15:8]);
        e.a_rd  = (av && !aw && asz == 2'd2) ? m_ptr : 32'h0;
        e.d_rd  = (fwd && !dw) ? (trd & msk(dsz)) : 32'h0;
        e.tv    = fwd;
        e.tw    = dw;
        e.bus   = m_ptr[23:16];
        e.devfn = m_ptr[15:8];
        e.off   = {m_ptr[7:2], dln};
        e.sz    = dsz;
        e.wd    = dwd;
        e.tag   = tag;
        q.push_back(e);
        if (av && aw && asz == 2'd2) m_ptr = awd;
    endtask

    task automatic pw(input logic [31:0] v, input string tag);
        cyc(1, 1, 2'd2, v, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, tag);
    endtask

    task automatic dr(input logic [1:0] ln, input logic [1:0] sz,
                      input logic [31:0] trd, input string tag);
        cyc(0, 0, 2'd0, 32'h0, 1, 0, ln, sz, 32'h0, trd, tag);
    endtask

    task automatic dwr(input logic [1:0] ln, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
        cyc(0, 0, 2'd0, 32'h0, 1, 1, ln, sz, wd, 32'h0, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (q.size() > 0) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                bad = (ptr_rdata !== e.a_rd) || (win_rdata !== e.d_rd) ||
                      (tgt_valid !== e.tv);
                if (e.tv && !bad) begin
                    bad = (tgt_write !== e.tw) || (tgt_bus !== e.bus) ||
                          (tgt_devfn !== e.devfn) || (tgt_offset !== e.off) ||
                          (tgt_size !== e.sz) ||
                          (e.tw && (tgt_wdata !== e.wd));
                end
                n_checks++;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got ptr_rd=%h win_rd=%h tv=%b tw=%b bus=%h devfn=%h off=%h sz=%0d wd=%h; exp ptr_rd=%h win_rd=%h tv=%b tw=%b bus=%h devfn=%h off=%h sz=%0d wd=%h",
                             e.tag, ptr_rdata, win_rdata, tgt_valid, tgt_write,
                             tgt_bus, tgt_devfn, tgt_offset, tgt_size, tgt_wdata,
                             e.a_rd, e.d_rd, e.tv, e.tw, e.bus, e.devfn, e.off,
                             e.sz, e.wd);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done && !reported) begin
            reported = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        slot_map[0*256 + 8'h00] = 1'b1;
        slot_map[0*256 + 8'h08] = 1'b1;
        slot_map[1*256 + 8'h11] = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cyc(1, 0, 2'd2, 32'h0, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, "R1 ptr after reset");
        dr(2'd0, 2'd2, 32'h1234_5678, "R1 window after reset");

        // R2 / R4: enable clear
        pw(32'h0000_0804, "R2 load disabled ptr");
        cyc(1, 0, 2'd2, 32'h0, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, "R2 ptr readback");
        dwr(2'd0, 2'd2, 32'h5555_AAAA, "R4 write while disabled");
        dr(2'd0, 2'd2, 32'hFFFF_FFFF, "R4 read while disabled");

        // R3: narrow pointer accesses ignored
        cyc(1, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, "R3 halfword ptr write");
        cyc(1, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, "R3 byte ptr write");
        cyc(1, 0, 2'd2, 32'h0, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, "R3 ptr unchanged");
        cyc(1, 0, 2'd0, 32'h0, 0, 0, 2'd0, 2'd0, 32'h0, 32'h0, "R3 byte ptr read zero");

        // R6 R7 R8 R10: forwarded accesses on bus0 devfn 0x08
        pw(32'h8000_0804, "R2 load enabled ptr");
        dr(2'd0, 2'd2, 32'hDEAD_BEEF, "R10 word read fwd");
        dr(2'd3, 2'd0, 32'h1122_3344, "R7 byte read lane3");
        dr(2'd2, 2'd1, 32'h1122_3344, "R10 halfword read lane2");
        dwr(2'd0, 2'd2, 32'hCAFE_F00D, "R6 word write fwd");
        dwr(2'd1, 2'd0, 32'h0000_00A5, "R8 byte write fwd");
        dr(2'd0, 2'd3, 32'hFFFF_FFFF, "R8 reserved width dropped");

        // R5: misaligned pointer
        pw(32'h8000_0806, "R5 load misaligned ptr");
        dwr(2'd0, 2'd2, 32'h1111_2222, "R5 write dropped");
        dr(2'd0, 2'd2, 32'h3333_4444, "R5 read zero");

        // R6 R7: bus1 devfn 0x11 top dword
        pw(32'h8001_11FC, "R6 load bus1 ptr");
        dr(2'd1, 2'd0, 32'h0000_00C3, "R7 offset FD");
        dr(2'd0, 2'd2, 32'h0BAD_F00D, "R6 bus1 word read");

        // R9: unpopulated targets
        pw(32'h8001_1200, "R9 empty slot ptr");
        dr(2'd0, 2'd2, 32'hFFFF_FFFF, "R9 empty slot read");
        dwr(2'd0, 2'd2, 32'h7777_7777, "R9 empty slot write");
        pw(32'h8005_0000, "R9 bus out of range ptr");
        dr(2'd0, 2'd2, 32'hFFFF_FFFF, "R9 bus out of range read");
        pw(32'h8000_1000, "R9 bus0 empty devfn ptr");
        dr(2'd0, 2'd2, 32'hFFFF_FFFF, "R9 bus0 empty devfn read");

        // R11: pointer write and window access in the same cycle
        pw(32'h8000_0004, "R11 setup populated");
        cyc(1, 1, 2'd2, 32'h8001_1200, 1, 0, 2'd1, 2'd1, 32'h0, 32'hAABB_CCDD,
            "R11 old ptr used (hit)");
        dr(2'd0, 2'd2, 32'hAABB_CCDD, "R11 new ptr miss");
        cyc(1, 1, 2'd2, 32'h8000_0008, 1, 0, 2'd0, 2'd2, 32'h0, 32'h0102_0304,
            "R11 old ptr used (miss)");
        dr(2'd0, 2'd2, 32'h0102_0304, "R11 new ptr hit");

        // idle cycle: no access
        cyc(0, 0, 2'd0, 32'h0, 0, 0, 2'd0, 2'd0, 32'h0, 32'hFFFF_FFFF, "R10 idle zero");

        repeat (3) @(posedge clk);
        done = 1'b1;
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    end

endmodule